// File: doc/BRIEF.md
# Non-overlapping sub-region grouping engine

The engine walks an ordered list of sub-region centre coordinates and splits it into groups whose members all sit far enough apart to be worked on at the same time. The list is expected in spiral-out order from the spectrum centre. The engine reads it through a simple read port: it drives an entry address, and the coordinate store returns the signed X/Y pair in the same cycle. A run is set by four values: the list length, a minimum separation D, a group-size cap N, and a start pulse.

Each group is seeded by the lowest-index entry that no group has taken yet. The engine then scans the entries above the seed in ascending order. It admits every free entry whose squared distance to each member already in the group is at least D squared. The scan stops when the group is full or when the list ends. One record goes out per group, carrying the group number, the member count and the member indices. When every entry has been consumed, a done pulse reports the total number of groups. Taken entries are marked in a bitmap; the coordinate store itself is never rewritten.

Top module: `subregion_grouper`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `grp_valid` and `done` are low.
- R2: Member slot 0 of every group record holds the lowest entry index that no earlier group has taken.
- R3: A candidate joins a group only if, for every member already in the group, dx*dx + dy*dy >= D*D. Exact equality counts as far enough.
- R4: Candidates are examined in ascending index order, and the earliest acceptable ones are taken. Members are packed in ascending index order, slot k at bits [k*IDX_W +: IDX_W] of `grp_members`.
- R5: The group-size limit is `max_group` clamped to MAX_N, with 0 treated as 1. A group holds between 1 and that limit of members, and fewer than the limit only when no further acceptable candidate remains.
- R6: Every entry below `list_len` appears in exactly one group. Groups are numbered 0, 1, 2, … in emission order. `done` pulses for one cycle with `done_groups` equal to the number of groups emitted.
- R7: A `list_len` of 0 emits no group, and `done` is high in the first cycle after the start edge, with `done_groups` = 0.
- R8: A `start` pulse while `busy` is high is ignored. `list_len`, `min_dist` and `max_group` are captured only at an accepted start.
- R9: `grp_valid` is high for exactly one cycle per record. Member slots at and above `grp_count` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run, accepted only when idle |
| list_len | input | IDX_W+1 | Number of entries in the list (at most MAX_ENTRIES) |
| min_dist | input | DIST_W | Minimum separation D (unsigned) |
| max_group | input | CNT_W | Requested group-size cap N |
| coord_addr | output | IDX_W | Entry index being read |
| coord_x | input | COORD_W | Signed X of the addressed entry, same cycle |
| coord_y | input | COORD_W | Signed Y of the addressed entry, same cycle |
| busy | output | 1 | A run is in progress |
| grp_valid | output | 1 | A group record is presented |
| grp_index | output | IDX_W | Group number of the record |
| grp_count | output | CNT_W | Member count of the record |
| grp_members | output | MAX_N*IDX_W | Packed member indices |
| done | output | 1 | One-cycle end-of-run pulse |
| done_groups | output | IDX_W+1 | Total groups of the run |

## Verification
The bench builds the engine with MAX_ENTRIES = 32, MAX_N = 4, COORD_W = 8 and DIST_W = 8. With these values a full list, a cap that has to be clamped (values 5 to 7 on a 3-bit field), the cap-of-zero case and negative coordinates all fit into short runs. A 25-point grid is grouped under separations of 0, 2 and a very large value, so the runs cover full groups, short groups and single-member groups. A two-point case places the pair exactly at distance D and then just inside it, which pins down the equality rule.

// File: rtl/grp_pkg.sv
// Package for the sub-region grouping engine.
// Holds the controller state encoding shared by the top module.
package grp_pkg;

    // Controller states of the grouping engine
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for start
        ST_SCAN,   // examining one candidate per cycle
        ST_EMIT,   // presenting the finished group record
        ST_HEAD,   // advancing to the lowest free entry
        ST_FIN     // end-of-run pulse
    } grp_state_t;

endpackage

// File: rtl/grp_sep_check.sv
// Separation test between a candidate centre and one group member.
// Output 'far' is high when the squared Euclidean distance is at least
// min_dist squared. Assumes two's complement signed coordinates.
module grp_sep_check #(
    parameter int COORD_W = 8,
    parameter int DIST_W  = 8
) (
    input  logic signed [COORD_W-1:0] cand_x,
    input  logic signed [COORD_W-1:0] cand_y,
    input  logic signed [COORD_W-1:0] memb_x,
    input  logic signed [COORD_W-1:0] memb_y,
    input  logic        [DIST_W-1:0]  min_dist,
    output logic                      far
);
    localparam int DW  = COORD_W + 1;
    localparam int SQW = 2 * DW;
    localparam int SUW = SQW + 1;
    localparam int SW  = (SUW > 2 * DIST_W) ? SUW : 2 * DIST_W;

    logic signed [DW-1:0] dx, dy;
    logic [DW-1:0]  ax, ay;
    logic [SQW-1:0] ax2, ay2;
    logic [SW-1:0]  sum_sq, lim_sq;

    // Differences, magnitudes and squared distance against D squared
    always_comb begin
        dx     = {cand_x[COORD_W-1], cand_x} - {memb_x[COORD_W-1], memb_x};
        dy     = {cand_y[COORD_W-1], cand_y} - {memb_y[COORD_W-1], memb_y};
        ax     = dx[DW-1] ? (~dx + DW'(1)) : dx;
        ay     = dy[DW-1] ? (~dy + DW'(1)) : dy;
        ax2    = SQW'(ax) * SQW'(ax);
        ay2    = SQW'(ay) * SQW'(ay);
        sum_sq = SW'(ax2) + SW'(ay2);
        lim_sq = SW'(min_dist) * SW'(min_dist);
        far    = (sum_sq >= lim_sq);
    end
endmodule

// File: rtl/grp_used_map.sv
// One bit per list entry marking entries already placed in a group.
// Synchronous clear of all bits, single-bit set, combinational read.
module grp_used_map #(
    parameter int ENTRIES = 256,
    parameter int IDX_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);
    logic [ENTRIES-1:0] used_q;

    // Bitmap update: reset/clear wins over set
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all)
            used_q <= '0;
        else if (set_en)
            used_q[set_idx] <= 1'b1;
    end

    // Read port
    assign rd_bit = used_q[rd_idx];
endmodule

// File: rtl/subregion_grouper.sv
// Greedy grouping engine for spiral-ordered sub-region centres.
// Seeds each group with the lowest free entry, then scans upward one entry
// per cycle and admits entries far enough from every current member, up to
// the clamped cap. Assumes list_len <= MAX_ENTRIES and a coordinate store
// that answers coord_addr in the same cycle.
module subregion_grouper #(
    parameter int MAX_ENTRIES = 256,
    parameter int MAX_N       = 4,
    parameter int COORD_W     = 8,
    parameter int DIST_W      = 8,
    localparam int IDX_W      = $clog2(MAX_ENTRIES),
    localparam int LEN_W      = IDX_W + 1,
    localparam int CNT_W      = $clog2(MAX_N + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [LEN_W-1:0]          list_len,
    input  logic [DIST_W-1:0]         min_dist,
    input  logic [CNT_W-1:0]          max_group,
    output logic [IDX_W-1:0]          coord_addr,
    input  logic signed [COORD_W-1:0] coord_x,
    input  logic signed [COORD_W-1:0] coord_y,
    output logic                      busy,
    output logic                      grp_valid,
    output logic [IDX_W-1:0]          grp_index,
    output logic [CNT_W-1:0]          grp_count,
    output logic [MAX_N*IDX_W-1:0]    grp_members,
    output logic                      done,
    output logic [LEN_W-1:0]          done_groups
);
    import grp_pkg::*;

    grp_state_t state;
    logic [IDX_W-1:0]  scan_q, head_q;
    logic [CNT_W-1:0]  cnt_q, cap_q, cap_in;
    logic [LEN_W-1:0]  len_q, left_q, gcount_q;
    logic [DIST_W-1:0] dist_q;
    logic [IDX_W-1:0]          memb_idx [MAX_N];
    logic signed [COORD_W-1:0] memb_x   [MAX_N];
    logic signed [COORD_W-1:0] memb_y   [MAX_N];
    logic [MAX_N-1:0] far_vec;
    logic used_bit, all_far, take, last_entry, full_after, accept_start;
    logic [IDX_W-1:0] rd_idx;

    // Clamp the requested cap into 1..MAX_N
    always_comb begin
        if (max_group == '0)
            cap_in = CNT_W'(1);
        else if (max_group > CNT_W'(MAX_N))
            cap_in = CNT_W'(MAX_N);
        else
            cap_in = max_group;
    end

    // One separation checker per member slot; empty slots pass
    for (genvar k = 0; k < MAX_N; k++) begin : g_sep
        logic far_k;
        grp_sep_check #(.COORD_W(COORD_W), .DIST_W(DIST_W)) u_sep (
            .cand_x  (coord_x),
            .cand_y  (coord_y),
            .memb_x  (memb_x[k]),
            .memb_y  (memb_y[k]),
            .min_dist(dist_q),
            .far     (far_k)
        );
        assign far_vec[k] = far_k || (cnt_q <= CNT_W'(k));
        assign grp_members[k*IDX_W +: IDX_W] = memb_idx[k];
    end

    assign accept_start = (state == ST_IDLE) && start;
    assign rd_idx       = (state == ST_HEAD) ? head_q : scan_q;
    assign coord_addr   = scan_q;
    assign all_far      = &far_vec;
    assign take         = (state == ST_SCAN) && !used_bit && all_far;
    assign last_entry   = (LEN_W'(scan_q) == len_q - LEN_W'(1));
    assign full_after   = take && (cnt_q + CNT_W'(1) == cap_q);

    grp_used_map #(.ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W)) u_used (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_all(accept_start),
        .set_en (take),
        .set_idx(scan_q),
        .rd_idx (rd_idx),
        .rd_bit (used_bit)
    );

    // Controller: run capture, candidate scan, emission and head advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            scan_q   <= '0;
            head_q   <= '0;
            cnt_q    <= '0;
            cap_q    <= CNT_W'(1);
            len_q    <= '0;
            left_q   <= '0;
            gcount_q <= '0;
            dist_q   <= '0;
            for (int k = 0; k < MAX_N; k++) begin
                memb_idx[k] <= '0;
                memb_x[k]   <= '0;
                memb_y[k]   <= '0;
            end
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        len_q    <= list_len;
                        left_q   <= list_len;
                        dist_q   <= min_dist;
                        cap_q    <= cap_in;
                        gcount_q <= '0;
                        head_q   <= '0;
                        scan_q   <= '0;
                        cnt_q    <= '0;
                        for (int k = 0; k < MAX_N; k++) memb_idx[k] <= '0;
                        state    <= (list_len == '0) ? ST_FIN : ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (take) begin
                        for (int k = 0; k < MAX_N; k++) begin
                            if (cnt_q == CNT_W'(k)) begin
                                memb_idx[k] <= scan_q;
                                memb_x[k]   <= coord_x;
                                memb_y[k]   <= coord_y;
                            end
                        end
                        cnt_q  <= cnt_q + CNT_W'(1);
                        left_q <= left_q - LEN_W'(1);
                    end
                    if (full_after || last_entry)
                        state <= ST_EMIT;
                    else
                        scan_q <= scan_q + IDX_W'(1);
                end
                ST_EMIT: begin
                    gcount_q <= gcount_q + LEN_W'(1);
                    state    <= (left_q == '0) ? ST_FIN : ST_HEAD;
                end
                ST_HEAD: begin
                    if (used_bit) begin
                        head_q <= head_q + IDX_W'(1);
                    end else begin
                        scan_q <= head_q;
                        cnt_q  <= '0;
                        for (int k = 0; k < MAX_N; k++) memb_idx[k] <= '0;
                        state  <= ST_SCAN;
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Record and status outputs
    assign busy        = (state != ST_IDLE);
    assign grp_valid   = (state == ST_EMIT);
    assign grp_index   = gcount_q[IDX_W-1:0];
    assign grp_count   = cnt_q;
    assign done        = (state == ST_FIN);
    assign done_groups = gcount_q;
endmodule

// File: rtl/grp_checker.sv
// Property checker for subregion_grouper, attached by bind below.
// Observes only the top-level ports.
module grp_checker #(
    parameter int IDX_W = 8,
    parameter int CNT_W = 3,
    parameter int MAX_N = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   busy,
    input logic                   grp_valid,
    input logic [CNT_W-1:0]       grp_count,
    input logic [MAX_N*IDX_W-1:0] grp_members,
    input logic                   done
);
    // R9: a record is presented for a single cycle
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |=> !grp_valid);

    // R5: member count inside 1..MAX_N
    a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> (grp_count != '0) && (grp_count <= CNT_W'(MAX_N)));

    // R6: end-of-run pulse never overlaps a record and returns to idle
    a_r6_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !grp_valid);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R1: nothing is reported while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!grp_valid && !done));

    // R4: packed members strictly ascending
    for (genvar k = 1; k < MAX_N; k++) begin : g_order
        a_r4_members_ascending: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_valid && grp_count > CNT_W'(k)) |->
            (grp_members[k*IDX_W +: IDX_W] > grp_members[(k-1)*IDX_W +: IDX_W]));
    end
endmodule

bind subregion_grouper grp_checker #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .MAX_N(MAX_N)
) u_grp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .grp_valid  (grp_valid),
    .grp_count  (grp_count),
    .grp_members(grp_members),
    .done       (done)
);

// File: tb/tb_subregion_grouper.sv
// Directed bench for subregion_grouper with an independent greedy model.
module tb_subregion_grouper;
    localparam int CLK_PERIOD = 10;
    localparam int ENT = 32;
    localparam int MN  = 4;
    localparam int IW  = 5;
    localparam int LW  = 6;
    localparam int CW  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LW-1:0] list_len = '0;
    logic [7:0] min_dist = '0;
    logic [CW-1:0] max_group = '0;
    logic [IW-1:0] coord_addr;
    logic signed [7:0] coord_x, coord_y;
    logic busy, grp_valid, done;
    logic [IW-1:0] grp_index;
    logic [CW-1:0] grp_count;
    logic [MN*IW-1:0] grp_members;
    logic [LW-1:0] done_groups;

    logic signed [7:0] bx [ENT];
    logic signed [7:0] by [ENT];
    int exp_cnt [ENT];
    int exp_mem [ENT][MN];
    int exp_groups;
    int got_groups;
    int n_checks = 0;
    int n_fail = 0;

    assign coord_x = bx[coord_addr];
    assign coord_y = by[coord_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    subregion_grouper #(.MAX_ENTRIES(ENT), .MAX_N(MN), .COORD_W(8), .DIST_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .list_len(list_len),
        .min_dist(min_dist), .max_group(max_group), .coord_addr(coord_addr),
        .coord_x(coord_x), .coord_y(coord_y), .busy(busy), .grp_valid(grp_valid),
        .grp_index(grp_index), .grp_count(grp_count), .grp_members(grp_members),
        .done(done), .done_groups(done_groups)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Greedy model built from the requirements
    task automatic model(input int len, input int d, input int mg);
        bit used [ENT];
        int cap, left, g;
        cap = (mg == 0) ? 1 : ((mg > MN) ? MN : mg);
        for (int i = 0; i < ENT; i++) used[i] = 1'b0;
        left = len;
        g = 0;
        while (left > 0) begin
            int c;
            c = 0;
            for (int k = 0; k < MN; k++) exp_mem[g][k] = 0;
            for (int i = 0; i < len && c < cap; i++) begin
                bit ok;
                if (used[i]) continue;
                ok = 1'b1;
                for (int k = 0; k < c; k++) begin
                    int dx, dy;
                    dx = int'(bx[i]) - int'(bx[exp_mem[g][k]]);
                    dy = int'(by[i]) - int'(by[exp_mem[g][k]]);
                    if (dx*dx + dy*dy < d*d) ok = 1'b0;
                end
                if (ok) begin
                    exp_mem[g][c] = i;
                    used[i] = 1'b1;
                    c++;
                    left--;
                end
            end
            exp_cnt[g] = c;
            g++;
        end
        exp_groups = g;
    endtask

    // Run one case and compare every record with the model
    task automatic run_case(input int len, input int d, input int mg, input bit glitch);
        int g, cyc;
        bit prev_v, fin;
        model(len, d, mg);
        @(negedge clk);
        list_len = LW'(len); min_dist = 8'(d); max_group = CW'(mg); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        g = 0; cyc = 1; prev_v = 1'b0; fin = 1'b0;
        while (!fin && cyc < 5000) begin
            if (glitch && cyc == 3) begin
                start = 1'b1; list_len = LW'(1); min_dist = 8'd0; max_group = CW'(1);
            end else if (glitch && cyc == 4) begin
                start = 1'b0;
            end
            if (grp_valid) begin
                chk(!prev_v, "R9 pulse", 1, 0);
                chk(g < exp_groups, "R6 extra group", g, exp_groups);
                if (g < exp_groups) begin
                    chk(int'(grp_index) == g, "R6 index", int'(grp_index), g);
                    chk(int'(grp_count) == exp_cnt[g], "R5 count", int'(grp_count), exp_cnt[g]);
                    chk(int'(grp_members[IW-1:0]) == exp_mem[g][0], "R2 seed",
                        int'(grp_members[IW-1:0]), exp_mem[g][0]);
                    for (int k = 1; k < MN; k++) begin
                        int a;
                        a = int'(grp_members[k*IW +: IW]);
                        if (k < exp_cnt[g])
                            chk(a == exp_mem[g][k], glitch ? "R8 member" : "R3/R4 member", a, exp_mem[g][k]);
                        else
                            chk(a == 0, "R9 empty slot", a, 0);
                    end
                end
                g++;
            end
            if (done) begin
                got_groups = int'(done_groups);
                chk(int'(done_groups) == exp_groups, "R6 total", int'(done_groups), exp_groups);
                chk(g == exp_groups, "R6 emitted", g, exp_groups);
                if (len == 0) chk(cyc == 1, "R7 done latency", cyc, 1);
                fin = 1'b1;
            end
            prev_v = grp_valid;
            if (!fin) begin
                @(negedge clk);
                cyc++;
            end
        end
        chk(fin, "R6 run finished", int'(fin), 1);
        @(negedge clk);
        chk(!busy, "R6 idle after done", int'(busy), 0);
    endtask

    task automatic load_grid();
        for (int i = 0; i < ENT; i++) begin
            bx[i] = (i < 25) ? 8'(i % 5 - 2) : 8'sd0;
            by[i] = (i < 25) ? 8'(i / 5 - 2) : 8'sd0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy, "R1 busy", int'(busy), 0);
        chk(!grp_valid, "R1 grp_valid", int'(grp_valid), 0);
        chk(!done, "R1 done", int'(done), 0);
    endtask

    task automatic t_grid();
        load_grid();
        run_case(25, 2, 4, 1'b0);
        run_case(25, 0, 3, 1'b0);   // R5 full groups of three
        run_case(25, 100, 4, 1'b0); // R5 singletons
        chk(got_groups == 25, "R5 singleton total", got_groups, 25);
    endtask

    task automatic t_equal();
        bx[0] = 8'sd0; by[0] = 8'sd0; bx[1] = 8'sd3; by[1] = 8'sd4;
        run_case(2, 5, 4, 1'b0);
        chk(got_groups == 1, "R3 equal distance accepted", got_groups, 1);
        run_case(2, 6, 4, 1'b0);
        chk(got_groups == 2, "R3 closer rejected", got_groups, 2);
    endtask

    task automatic t_zero();
        run_case(0, 3, 4, 1'b0);
        chk(got_groups == 0, "R7 zero groups", got_groups, 0);
    endtask

    task automatic t_busy_start();
        load_grid();
        run_case(25, 2, 4, 1'b1);
    endtask

    task automatic t_cap_clamp();
        load_grid();
        run_case(25, 0, 0, 1'b0);
        chk(got_groups == 25, "R5 cap zero as one", got_groups, 25);
        run_case(25, 0, 7, 1'b0);
        chk(got_groups == 7, "R5 cap clamped", got_groups, 7);
    endtask

    task automatic t_negative();
        for (int i = 0; i < ENT; i++) begin
            bx[i] = 8'(-100 + 7 * i);
            by[i] = 8'(90 - 5 * i);
        end
        run_case(32, 20, 4, 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_grid();
        t_equal();
        t_zero();
        t_busy_start();
        t_cap_clamp();
        t_negative();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule